// File: doc/BRIEF.md
# Conversion Start/Stop Control Sequencer

This block is the conversion-control state machine of a delta-sigma converter. It decides when a conversion begins, when one is aborted and begun again, and when the converter goes quiet. Two sources can trigger it. The first is an external start pin, which is synchronised and width-qualified inside the block. The second is a pair of single-cycle start and stop command pulses from the serial command decoder. A mode input selects one of two behaviours. In gate mode (`pulse_mode_i` = 0) conversions repeat back to back until a stop is requested. In pulse mode (`pulse_mode_i` = 1) each trigger yields a single conversion.

An internal down-counter stands in for the modulator and filter. It is loaded with `conv_len_i` cycles per conversion. The block drives an active-low data-ready strobe: `drdy_o` is high while a result is being produced and low once it is available. When a restart arrives too soon after a result, the converter produces a short, unsettled conversion. The block gives that conversion a shorter length and raises `discard_o` alongside its data-ready edge, so that the host can drop the result.

The states are `ST_IDLE` (halted), `ST_RUN` (converting, another conversion follows), `ST_ONE_MORE` (converting, exactly one further conversion follows, then halt) and `ST_LAST` (converting, halt when this one ends). The transitions are as follows.
- Launch: `ST_IDLE` to a converting state on a start event.
- Restart: any converting state back to its launch state on a start event, with the timer reloaded.
- Chain: when a conversion ends, `ST_RUN` stays in `ST_RUN`, and `ST_ONE_MORE` moves to `ST_LAST`.
- Retire: when a conversion ends in `ST_LAST`, the block moves to `ST_IDLE`.
- Stop-early: a stop with at least `STOP_SU` cycles remaining moves to `ST_LAST`.
- Stop-late: a stop with fewer cycles remaining moves `ST_RUN` to `ST_ONE_MORE`.

Top module: `conv_ctrl_seq`

## Requirements
- R1: After reset `drdy_o` = 1, `converting_o` = 0 and `discard_o` = 0, and the block stays idle until a start event. `pulse_mode_i` = 0 selects gate mode and 1 selects pulse mode.
- R2: A normal conversion keeps `drdy_o` high for exactly `conv_len_i` cycles after it launches, and `drdy_o` then falls. Between back-to-back conversions `drdy_o` is low for exactly one cycle and `converting_o` stays 1.
- R3: In gate mode, a start (command pulse or qualified pin rise) launches conversions that repeat without limit until a stop request.
- R4: In pulse mode, each start runs one conversion. `converting_o` drops on the same edge that `drdy_o` falls, and the block stays idle afterwards.
- R5: The pin passes through two synchroniser flops and must hold a new level for 4 cycles to count. `converting_o` and `drdy_o` rise on the 6th clock edge that samples the raised pin. Pin pulses shorter than 4 cycles have no effect.
- R6: A qualified falling pin edge is a stop request in gate mode and has no effect in pulse mode.
- R7: A stop request lets the running conversion complete. If `STOP_SU` (16) or more counts remain when the request is sampled, the block halts on that conversion's `drdy_o` falling edge.
- R8: A stop request sampled with fewer than 16 counts remaining lets exactly one more full conversion run before the halt.
- R9: A start event during a conversion aborts it without a `drdy_o` falling edge, and a fresh full conversion is timed from that event.
- R10: A start event sampled on any of the 22 edges that follow a `drdy_o` falling edge launches a conversion of `EARLY_LEN` (8) cycles. That conversion is followed by one full conversion even in pulse mode. A start sampled on the 23rd edge or later is a normal start.
- R11: A stop request in the same cycle as a start command or pin rise wins: the start is ignored.
- R12: `discard_o` changes only on `drdy_o` falling edges. It is 1 after the fall of a short post-restart conversion and 0 after the fall of a full one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pin_i | input | 1 | Asynchronous external start pin |
| cmd_start_i | input | 1 | Single-cycle start command pulse |
| cmd_stop_i | input | 1 | Single-cycle stop command pulse |
| pulse_mode_i | input | 1 | 0 = gate mode, 1 = pulse mode |
| conv_len_i | input | LEN_W | Full conversion length in cycles (at least 2) |
| drdy_o | output | 1 | Active-low data-ready strobe |
| converting_o | output | 1 | High while a conversion is in progress |
| discard_o | output | 1 | Marks the latest result as invalid |

## Verification
The embedded properties watch, on every cycle, the invariants that tie the outputs together. `drdy_o` is high whenever converting begins. Conversions end only with `drdy_o` low. `discard_o` moves only on a data-ready fall. A colliding start and stop never launches a conversion. The timer counts down by one per cycle. The pin qualifier adopts the synchronised level when it fires. The exact cycle counts can only be shown by directed scenarios, because they depend on sequences of stimulus rather than on single-cycle relations. Those counts cover the pin latency, the 16-count stop boundary on either side, the 22-edge early window and its first edge outside, restart timing, and the extra conversion after a short one.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN      = 2'd1,
        ST_ONE_MORE = 2'd2,
        ST_LAST     = 2'd3
    } seq_state_e;

endpackage

// File: rtl/ccs_pin_qual.sv
module ccs_pin_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int PW_MIN      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(PW_MIN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic                   level_q;
    logic [CW-1:0]          cnt_q;
    logic                   hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    assign synced = sync_q[SYNC_STAGES-1];
    assign hit    = (synced != level_q) && (cnt_q == CW'(PW_MIN - 1));
    assign rise_o = hit && synced;
    assign fall_o = hit && !synced;

    // width qualifier: a new level must persist PW_MIN cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            cnt_q   <= '0;
        end else if (synced == level_q) begin
            cnt_q   <= '0;
        end else if (hit) begin
            level_q <= synced;
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + CW'(1);
        end
    end

    a_r5_qual_adopts_level: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (level_q == $past(synced)));

endmodule

// File: rtl/ccs_len_timer.sv
module ccs_len_timer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] load_val_i,
    input  logic             run_i,
    output logic [LEN_W-1:0] remain_o,
    output logic             done_o
);
    logic [LEN_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          remain_q <= '0;
        else if (load_i)                     remain_q <= load_val_i;
        else if (run_i && remain_q != '0)    remain_q <= remain_q - LEN_W'(1);
    end

    assign remain_o = remain_q;
    assign done_o   = run_i && (remain_q == '0);

    a_r2_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && remain_q != '0) |=> (remain_q == $past(remain_q) - LEN_W'(1)));

endmodule

// File: rtl/ccs_rearm_win.sv
module ccs_rearm_win #(
    parameter int WIN = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    output logic in_win_o
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   age_q <= CW'(WIN);
        else if (fall_i)              age_q <= '0;
        else if (age_q < CW'(WIN))    age_q <= age_q + CW'(1);
    end

    assign in_win_o = age_q < CW'(WIN);

    a_r10_age_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q <= CW'(WIN)));

endmodule

// File: rtl/conv_ctrl_seq.sv
module conv_ctrl_seq
    import ccs_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PW_MIN      = 4,
    parameter int STOP_SU     = 16,
    parameter int REARM_WIN   = 22,
    parameter int EARLY_LEN   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_pin_i,
    input  logic             cmd_start_i,
    input  logic             cmd_stop_i,
    input  logic             pulse_mode_i,
    input  logic [LEN_W-1:0] conv_len_i,
    output logic             drdy_o,
    output logic             converting_o,
    output logic             discard_o
);
    localparam logic [LEN_W-1:0] EARLY_LOAD = LEN_W'(EARLY_LEN - 1);
    localparam logic [LEN_W-1:0] SU_COUNT   = LEN_W'(STOP_SU);

    seq_state_e       state_q, state_d, launch_state;
    logic             early_q, early_d;
    logic             pin_rise, pin_fall;
    logic             stop_ev, start_ev, early_start, in_win;
    logic             busy, tmr_done, tmr_load, fall_ev, stop_in_time;
    logic [LEN_W-1:0] remain, load_val, full_load;

    ccs_pin_qual #(.SYNC_STAGES(SYNC_STAGES), .PW_MIN(PW_MIN)) u_pin (
        .clk(clk), .rst_n(rst_n), .pin_i(start_pin_i),
        .rise_o(pin_rise), .fall_o(pin_fall)
    );

    ccs_len_timer #(.LEN_W(LEN_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(load_val),
        .run_i(busy), .remain_o(remain), .done_o(tmr_done)
    );

    ccs_rearm_win #(.WIN(REARM_WIN)) u_win (
        .clk(clk), .rst_n(rst_n), .fall_i(fall_ev), .in_win_o(in_win)
    );

    // event decoding: a stop request beats any simultaneous start
    assign stop_ev      = cmd_stop_i || (pin_fall && !pulse_mode_i);
    assign start_ev     = (cmd_start_i || pin_rise) && !stop_ev;
    assign early_start  = start_ev && in_win;
    assign busy         = (state_q != ST_IDLE);
    assign stop_in_time = (remain >= SU_COUNT);
    assign full_load    = conv_len_i - LEN_W'(1);

    always_comb begin
        if (early_start) launch_state = pulse_mode_i ? ST_ONE_MORE : ST_RUN;
        else             launch_state = pulse_mode_i ? ST_LAST     : ST_RUN;
    end

    // next-state logic
    always_comb begin
        state_d  = state_q;
        early_d  = early_q;
        tmr_load = 1'b0;
        load_val = full_load;
        fall_ev  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ev) begin                       // launch
                    state_d  = launch_state;
                    tmr_load = 1'b1;
                    load_val = early_start ? EARLY_LOAD : full_load;
                    early_d  = early_start;
                end
            end
            ST_RUN, ST_ONE_MORE, ST_LAST: begin
                if (start_ev) begin                       // restart
                    state_d  = launch_state;
                    tmr_load = 1'b1;
                    load_val = early_start ? EARLY_LOAD : full_load;
                    early_d  = early_start;
                end else if (tmr_done) begin
                    fall_ev = 1'b1;
                    early_d = 1'b0;
                    if (state_q == ST_LAST) begin         // retire
                        state_d = ST_IDLE;
                    end else begin                        // chain
                        tmr_load = 1'b1;
                        state_d  = (state_q == ST_ONE_MORE || stop_ev) ? ST_LAST : ST_RUN;
                    end
                end else if (stop_ev) begin
                    if (stop_in_time)           state_d = ST_LAST;     // stop-early
                    else if (state_q == ST_RUN) state_d = ST_ONE_MORE; // stop-late
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            early_q <= 1'b0;
        end else begin
            state_q <= state_d;
            early_q <= early_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drdy_o       <= 1'b1;
            converting_o <= 1'b0;
            discard_o    <= 1'b0;
        end else begin
            converting_o <= (state_d != ST_IDLE);
            if (fall_ev) begin
                drdy_o    <= 1'b0;
                discard_o <= early_q;
            end else if (state_d != ST_IDLE) begin
                drdy_o    <= 1'b1;
            end
        end
    end

    a_r2_drdy_high_at_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(converting_o) |-> drdy_o);

    a_r4_halt_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(converting_o) |-> !drdy_o);

    a_r11_stop_beats_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_start_i && cmd_stop_i) |=> !converting_o);

    a_r12_discard_only_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(drdy_o) |-> $stable(discard_o));

    a_r4_last_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAST && tmr_done && !cmd_start_i && !pin_rise) |=> !converting_o);

endmodule

// File: tb/test_conv_ctrl_seq.sv
module test_conv_ctrl_seq;

    localparam int CLK_P = 20;
    localparam int L     = 40;
    localparam int EL    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_pin = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_stop = 1'b0;
    logic        pulse_mode = 1'b0;
    logic [15:0] conv_len = 16'(L);
    logic        drdy, converting, discard;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    conv_ctrl_seq i_conv_ctrl_seq (
        .clk(clk), .rst_n(rst_n), .start_pin_i(start_pin),
        .cmd_start_i(cmd_start), .cmd_stop_i(cmd_stop),
        .pulse_mode_i(pulse_mode), .conv_len_i(conv_len),
        .drdy_o(drdy), .converting_o(converting), .discard_o(discard)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        cmd_start = 1'b1; step(1); cmd_start = 1'b0;
    endtask

    task automatic pulse_stop();
        cmd_stop = 1'b1; step(1); cmd_stop = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "drdy after reset", drdy, 1);
        chk("R1", "converting after reset", converting, 0);
        chk("R1", "discard after reset", discard, 0);
        step(10);
        chk("R1", "idle without start", converting, 0);
    endtask

    task automatic t_pulse_cmd();
        pulse_mode = 1'b1; step(30);
        pulse_start();
        chk("R4", "converting at launch", converting, 1);
        chk("R2", "drdy at launch", drdy, 1);
        step(L-1);
        chk("R2", "drdy before end", drdy, 1);
        step(1);
        chk("R2", "drdy falls after conv_len", drdy, 0);
        chk("R4", "halted after one", converting, 0);
        chk("R12", "discard on full result", discard, 0);
        step(30);
        chk("R4", "stays idle", converting, 0);
    endtask

    task automatic t_gate_cont();
        pulse_mode = 1'b0; step(30);
        pulse_start();
        step(L);
        chk("R2", "first fall", drdy, 0);
        chk("R3", "continues", converting, 1);
        step(1);
        chk("R2", "one-cycle low", drdy, 1);
        step(L-1);
        chk("R3", "second fall", drdy, 0);
        step(23); pulse_stop();          // sampled with 16 remaining
        step(15);
        chk("R7", "current completes", drdy, 1);
        step(1);
        chk("R7", "fall at end", drdy, 0);
        chk("R7", "halted at 16 remaining", converting, 0);
    endtask

    task automatic t_late_stop();
        pulse_mode = 1'b0; step(30);
        pulse_start();
        step(24); pulse_stop();          // sampled with 15 remaining
        step(15);
        chk("R8", "fall of current", drdy, 0);
        chk("R8", "one more runs", converting, 1);
        step(1);
        chk("R8", "drdy back high", drdy, 1);
        step(L-1);
        chk("R8", "extra conversion falls", drdy, 0);
        chk("R8", "halted after extra", converting, 0);
    endtask

    task automatic t_pin_gate();
        pulse_mode = 1'b0; step(30);
        start_pin = 1'b1;
        step(5);
        chk("R5", "not yet on 5th edge", converting, 0);
        step(1);
        chk("R5", "converting on 6th edge", converting, 1);
        chk("R5", "drdy on 6th edge", drdy, 1);
        step(L);
        chk("R3", "pin-held continuous", converting, 1);
        chk("R3", "pin-held fall", drdy, 0);
        step(1);
        start_pin = 1'b0;
        step(L-1);
        chk("R6", "pin fall halts", converting, 0);
        chk("R6", "final fall", drdy, 0);
    endtask

    task automatic t_pin_width();
        pulse_mode = 1'b1; step(30);
        start_pin = 1'b1; step(3); start_pin = 1'b0;
        step(20);
        chk("R5", "3-cycle pulse ignored", converting, 0);
        start_pin = 1'b1; step(4); start_pin = 1'b0;
        step(1);
        chk("R5", "4-cycle pulse, 5th edge", converting, 0);
        step(1);
        chk("R5", "4-cycle pulse accepted", converting, 1);
        step(L-1);
        chk("R6", "pulse-mode fall ignored", drdy, 1);
        chk("R6", "still converting", converting, 1);
        step(1);
        chk("R4", "single conversion ends", converting, 0);
    endtask

    task automatic t_restart();
        pulse_mode = 1'b1; step(30);
        pulse_start();
        step(10); pulse_start();
        step(L-12);
        step(1);
        chk("R9", "no fall for aborted", drdy, 1);
        chk("R9", "still converting", converting, 1);
        step(10);
        chk("R9", "high before new end", drdy, 1);
        step(1);
        chk("R9", "fall from restart point", drdy, 0);
        chk("R9", "halted", converting, 0);
    endtask

    task automatic t_early();
        pulse_mode = 1'b1; step(30);
        pulse_start();
        step(L);
        chk("R10", "base fall", drdy, 0);
        step(4); pulse_start();          // 5th edge after fall
        step(EL-1);
        chk("R10", "short conv pending", drdy, 1);
        chk("R12", "discard not yet", discard, 0);
        step(1);
        chk("R10", "short conv falls", drdy, 0);
        chk("R12", "discard raised", discard, 1);
        chk("R10", "follow-on in pulse mode", converting, 1);
        step(1);
        chk("R12", "discard held", discard, 1);
        step(L-1);
        chk("R10", "valid fall", drdy, 0);
        chk("R12", "discard cleared", discard, 0);
        chk("R10", "halted after valid", converting, 0);
        step(21); pulse_start();         // 22nd edge after fall
        step(EL);
        chk("R10", "22nd edge is early", drdy, 0);
        chk("R12", "discard on edge 22", discard, 1);
        step(L);
        chk("R10", "valid after edge-22 restart", drdy, 0);
        chk("R12", "discard clear again", discard, 0);
        step(22); pulse_start();         // 23rd edge after fall
        step(EL);
        chk("R10", "23rd edge is normal", drdy, 1);
        step(L-EL);
        chk("R10", "normal length fall", drdy, 0);
        chk("R12", "normal result kept", discard, 0);
        chk("R4", "idle after normal", converting, 0);
    endtask

    task automatic t_stop_wins();
        pulse_mode = 1'b0; step(30);
        cmd_start = 1'b1; cmd_stop = 1'b1;
        step(1);
        cmd_start = 1'b0; cmd_stop = 1'b0;
        step(3);
        chk("R11", "stop beats start", converting, 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_pulse_cmd();
        t_gate_cont();
        t_late_stop();
        t_pin_gate();
        t_pin_width();
        t_restart();
        t_early();
        t_stop_wins();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule